// File: doc/BRIEF.md
# Constant-Pattern Scalar Ladder Sequencer

This block runs the control side of a fixed-base-point scalar multiplication on a twisted Edwards curve. It takes a 256-bit scalar, made of eight 32-bit words with word 0 in bits 31:0, and clamps it. It then steps through the clamped bits from the least significant bit to the most significant bit. The block does no arithmetic. It sends a separate point engine a series of commands over a request/acknowledge channel. The engine holds two accumulator points, R0 and R1, plus the working slots.

A run has three phases:
- **Load.** One command tells the engine to set R0 to the neutral point (X=0, Y=1, Z=1, T=0) and R1 to the base point (Z=1 with its precomputed X, Y and T).
- **Steps.** There are 256 step commands, one per scalar bit. Each step is one doubling followed by one addition, whatever the bit value. The bit only decides which accumulator is copied into the doubled slot U, which is copied into the addend slot V, and which accumulator receives U doubled plus V.
- **Finish.** A last command asks for inversion and conversion, with R0 named as the source of the Z coordinate.

Each command is held on the outputs until the engine acknowledges it. The sequencer never moves on without that acknowledgement.

Top module: `ladder_seq`

## Requirements
- R1: The scalar bits the steps use are the input scalar with bits 0, 1 and 2 forced to 0, bit 255 forced to 0 and bit 254 forced to 1. Steps 0 to 2 and step 255 therefore always act as 0-bits, and step 254 always acts as a 1-bit.
- R2: Steps are issued in order of `cmd_idx_o` = 0, 1, …, 255. Step i uses bit i of the clamped scalar, which is bit i mod 32 of word i/32.
- R3: After an accepted start, the first command is load: `cmd_op_o`=1, with `cmd_idx_o`=0 and `cmd_u_o`, `cmd_v_o` and `cmd_dst_o` all 0.
- R4: A step for a 1-bit has `cmd_op_o`=2, `cmd_u_o`=0 (R0), `cmd_v_o`=1 (R1) and `cmd_dst_o`=0. Register select 0 means R0 and 1 means R1.
- R5: A step for a 0-bit has `cmd_op_o`=2, `cmd_u_o`=1, `cmd_v_o`=0 and `cmd_dst_o`=1.
- R6: Every step uses the same operation code, 2, whatever the bit value. Exactly 256 step commands are issued per run.
- R7: After step 255 is acknowledged, the next command is finish: `cmd_op_o`=3, `cmd_u_o`=0 (R0 supplies Z), `cmd_v_o`=0, `cmd_dst_o`=0 and `cmd_idx_o`=255. No further command follows it.
- R8: While `cmd_req_o` is high and `cmd_ack_i` is low, all command outputs hold their values. A command is consumed only on a clock edge where both are high.
- R9: A start pulse while `busy_o` is high has no effect on the command stream.
- R10: The scalar is captured on the accepted start. Later changes to `scalar_i` do not affect the run.
- R11: `done_o` pulses high for one cycle, in the cycle after the finish command is acknowledged. `busy_o` is low in that cycle.
- R12: After reset, `busy_o`, `done_o` and `cmd_req_o` are 0 and `cmd_op_o` is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when idle |
| scalar_i | input | 256 | Scalar, word w in bits 32w+31:32w |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_req_o | output | 1 | Command valid toward the point engine |
| cmd_ack_i | input | 1 | Engine accepts the current command |
| cmd_op_o | output | 2 | 0 none, 1 load, 2 step, 3 finish |
| cmd_u_o | output | 1 | Accumulator copied into the doubled slot (or Z source on finish) |
| cmd_v_o | output | 1 | Accumulator copied into the addend slot |
| cmd_dst_o | output | 1 | Accumulator written with the step result |
| cmd_idx_o | output | 8 | Index of the current bit |

## Verification
After the start edge, the load command appears on the first clock edge. Each following command appears on the edge at which the previous one is acknowledged. `done_o` rises on the edge that takes the finish acknowledgement.

The bench's engine model samples and acknowledges on falling edges. It therefore reads each command half a cycle after it became valid. It compares the command against the head of a queue that was filled from the clamped scalar before start. It checks `done_o` and `busy_o` on the falling edge right after the finish acknowledgement, and again one cycle later.

Acknowledge delays vary from zero to several cycles. If a command moved on without its acknowledgement, an index in the sequence would be skipped.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_LOAD   = 2'd1,
      OP_STEP   = 2'd2,
      OP_FINISH = 2'd3
   } cmd_op_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_STEP,
      ST_FIN
   } seq_state_t;

   localparam logic SEL_R0 = 1'b0;
   localparam logic SEL_R1 = 1'b1;

endpackage

// File: rtl/ladder_clamp.sv
module ladder_clamp #(
   parameter int WORD_W     = 32,
   parameter int NUM_WORDS  = 8,
   parameter int LOW_CLEAR  = 3,
   localparam int N_BITS    = WORD_W * NUM_WORDS
) (
   input  logic [N_BITS-1:0] raw_i,
   output logic [N_BITS-1:0] clamped_o
);

   if (WORD_W < 4) begin : g_bad_word
      $error("ladder_clamp: WORD_W too small");
   end
   if (LOW_CLEAR >= WORD_W) begin : g_bad_low
      $error("ladder_clamp: LOW_CLEAR must be below WORD_W");
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_in;
      logic [WORD_W-1:0] word_out;
      assign word_in = raw_i[w*WORD_W +: WORD_W];

      if (w == 0 && NUM_WORDS == 1) begin : g_single
         always_comb begin
            word_out = word_in;
            word_out[LOW_CLEAR-1:0] = '0;
            word_out[WORD_W-1] = 1'b0;
            word_out[WORD_W-2] = 1'b1;
         end
      end else if (w == 0) begin : g_low
         always_comb begin
            word_out = word_in;
            word_out[LOW_CLEAR-1:0] = '0;
         end
      end else if (w == NUM_WORDS - 1) begin : g_top
         always_comb begin
            word_out = word_in;
            word_out[WORD_W-1] = 1'b0;
            word_out[WORD_W-2] = 1'b1;
         end
      end else begin : g_mid
         assign word_out = word_in;
      end

      assign clamped_o[w*WORD_W +: WORD_W] = word_out;
   end

endmodule

// File: rtl/ladder_bitwalk.sv
module ladder_bitwalk #(
   parameter int N_BITS    = 256,
   parameter bit PICK_SHIFT = 1'b1,
   localparam int IDX_W    = $clog2(N_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [N_BITS-1:0] scalar_i,
   input  logic              adv_i,
   output logic              bit_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              last_o
);

   if (N_BITS < 2) begin : g_bad_bits
      $error("ladder_bitwalk: N_BITS must be at least 2");
   end

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (load_i) begin
         idx_q <= '0;
      end else if (adv_i) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   if (PICK_SHIFT) begin : g_shift
      logic [N_BITS-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else if (load_i) begin
            sh_q <= scalar_i;
         end else if (adv_i) begin
            sh_q <= {1'b0, sh_q[N_BITS-1:1]};
         end
      end
      assign bit_o = sh_q[0];
   end else begin : g_index
      logic [N_BITS-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (load_i) begin
            hold_q <= scalar_i;
         end
      end
      assign bit_o = hold_q[idx_q];
   end

   assign idx_o  = idx_q;
   assign last_o = (idx_q == IDX_W'(N_BITS - 1));

endmodule

// File: rtl/ladder_roles.sv
module ladder_roles
   import ladder_pkg::*;
(
   input  logic step_i,
   input  logic fin_i,
   input  logic bit_i,
   output logic u_o,
   output logic v_o,
   output logic dst_o
);

   always_comb begin
      u_o   = SEL_R0;
      v_o   = SEL_R0;
      dst_o = SEL_R0;
      if (step_i) begin
         // a set bit doubles R0 and adds R1; a clear bit the reverse
         u_o   = bit_i ? SEL_R0 : SEL_R1;
         v_o   = bit_i ? SEL_R1 : SEL_R0;
         dst_o = bit_i ? SEL_R0 : SEL_R1;
      end else if (fin_i) begin
         u_o   = SEL_R0;
      end
   end

endmodule

// File: rtl/ladder_seq.sv
module ladder_seq
   import ladder_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int NUM_WORDS  = 8,
   parameter int LOW_CLEAR  = 3,
   parameter bit PICK_SHIFT = 1'b1,
   localparam int N_BITS    = WORD_W * NUM_WORDS,
   localparam int IDX_W     = $clog2(N_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [N_BITS-1:0] scalar_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              cmd_req_o,
   input  logic              cmd_ack_i,
   output logic [1:0]        cmd_op_o,
   output logic              cmd_u_o,
   output logic              cmd_v_o,
   output logic              cmd_dst_o,
   output logic [IDX_W-1:0]  cmd_idx_o
);

   seq_state_t        state_q, state_d;
   logic              done_q;
   logic [N_BITS-1:0] clamped;
   logic              take_start;
   logic              accept;
   logic              adv;
   logic              cur_bit;
   logic              is_last;

   ladder_clamp #(
      .WORD_W    (WORD_W),
      .NUM_WORDS (NUM_WORDS),
      .LOW_CLEAR (LOW_CLEAR)
   ) u_clamp (
      .raw_i     (scalar_i),
      .clamped_o (clamped)
   );

   assign take_start = (state_q == ST_IDLE) && start_i;
   assign accept     = cmd_req_o && cmd_ack_i;
   assign adv        = accept && (state_q == ST_STEP) && !is_last;

   ladder_bitwalk #(
      .N_BITS     (N_BITS),
      .PICK_SHIFT (PICK_SHIFT)
   ) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (take_start),
      .scalar_i (clamped),
      .adv_i    (adv),
      .bit_o    (cur_bit),
      .idx_o    (cmd_idx_o),
      .last_o   (is_last)
   );

   ladder_roles u_roles (
      .step_i (state_q == ST_STEP),
      .fin_i  (state_q == ST_FIN),
      .bit_i  (cur_bit),
      .u_o    (cmd_u_o),
      .v_o    (cmd_v_o),
      .dst_o  (cmd_dst_o)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i)   state_d = ST_LOAD;
         ST_LOAD: if (cmd_ack_i) state_d = ST_STEP;
         ST_STEP: if (cmd_ack_i && is_last) state_d = ST_FIN;
         ST_FIN:  if (cmd_ack_i) state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= accept && (state_q == ST_FIN);
      end
   end

   always_comb begin
      unique case (state_q)
         ST_LOAD: cmd_op_o = OP_LOAD;
         ST_STEP: cmd_op_o = OP_STEP;
         ST_FIN:  cmd_op_o = OP_FINISH;
         default: cmd_op_o = OP_NONE;
      endcase
   end

   assign cmd_req_o = (state_q != ST_IDLE);
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;

endmodule

// File: rtl/ladder_seq_chk.sv
module ladder_seq_chk #(
   parameter int N_BITS = 256,
   parameter int IDX_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             cmd_req_o,
   input logic             cmd_ack_i,
   input logic [1:0]       cmd_op_o,
   input logic             cmd_u_o,
   input logic             cmd_v_o,
   input logic             cmd_dst_o,
   input logic [IDX_W-1:0] cmd_idx_o
);

   p_clamp_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op_o == 2'd2 && cmd_idx_o < IDX_W'(3)) |-> cmd_dst_o == 1'b1);

   p_clamp_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op_o == 2'd2 && cmd_idx_o == IDX_W'(N_BITS - 1)) |-> cmd_dst_o == 1'b1);

   p_clamp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op_o == 2'd2 && cmd_idx_o == IDX_W'(N_BITS - 2)) |-> cmd_dst_o == 1'b0);

   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && cmd_ack_i && cmd_op_o == 2'd2 && cmd_idx_o != IDX_W'(N_BITS - 1))
      |=> (cmd_op_o == 2'd2 && cmd_idx_o == IDX_W'($past(cmd_idx_o) + 1'b1)));

   p_load_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (cmd_op_o == 2'd1 && cmd_idx_o == '0));

   p_roles_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op_o == 2'd2 && cmd_dst_o == 1'b0) |-> (cmd_u_o == 1'b0 && cmd_v_o == 1'b1));

   p_roles_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op_o == 2'd2 && cmd_dst_o == 1'b1) |-> (cmd_u_o == 1'b1 && cmd_v_o == 1'b0));

   p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && cmd_ack_i && cmd_op_o == 2'd2 && cmd_idx_o == IDX_W'(N_BITS - 1))
      |=> (cmd_op_o == 2'd3 && cmd_u_o == 1'b0));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_op_o) && $stable(cmd_idx_o)
                                     && $stable(cmd_dst_o)));

   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !cmd_ack_i) |=> ($stable(cmd_idx_o) && $stable(cmd_op_o)));

   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!cmd_req_o && cmd_op_o == 2'd0));

endmodule

bind ladder_seq ladder_seq_chk #(
   .N_BITS (N_BITS),
   .IDX_W  (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .cmd_req_o (cmd_req_o),
   .cmd_ack_i (cmd_ack_i),
   .cmd_op_o  (cmd_op_o),
   .cmd_u_o   (cmd_u_o),
   .cmd_v_o   (cmd_v_o),
   .cmd_dst_o (cmd_dst_o),
   .cmd_idx_o (cmd_idx_o)
);

// File: tb/tb_ladder_seq.sv
`timescale 1ns/1ps
module tb_ladder_seq;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [255:0] scalar_i = '0;
   logic         busy_o, done_o, cmd_req_o;
   logic         cmd_ack_i = 1'b0;
   logic [1:0]   cmd_op_o;
   logic         cmd_u_o, cmd_v_o, cmd_dst_o;
   logic [7:0]   cmd_idx_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int dly_seed = 0;
   int wait_cnt = 0;
   logic [12:0] exp_q[$];

   always #4 clk = ~clk;

   ladder_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .scalar_i(scalar_i),
      .busy_o(busy_o), .done_o(done_o), .cmd_req_o(cmd_req_o), .cmd_ack_i(cmd_ack_i),
      .cmd_op_o(cmd_op_o), .cmd_u_o(cmd_u_o), .cmd_v_o(cmd_v_o), .cmd_dst_o(cmd_dst_o),
      .cmd_idx_o(cmd_idx_o)
   );

   function automatic string tag_of(logic [12:0] e);
      if (e[12:11] == 2'd1) return "R3";
      if (e[12:11] == 2'd3) return "R7";
      if (e[7:0] < 8'd3 || e[7:0] >= 8'd254) return "R1";
      return e[8] ? "R5" : "R4";
   endfunction

   task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // driver: pushes the expected command stream computed from the clamped scalar
   task automatic push_expected(logic [255:0] k);
      logic [255:0] kc;
      kc = k;
      kc[2:0] = 3'b000;
      kc[255] = 1'b0;
      kc[254] = 1'b1;
      exp_q.push_back({2'd1, 1'b0, 1'b0, 1'b0, 8'd0});
      for (int i = 0; i < 256; i++) begin
         logic u;
         u = kc[i] ? 1'b0 : 1'b1;
         exp_q.push_back({2'd2, u, ~u, u, 8'(i)});
      end
      exp_q.push_back({2'd3, 1'b0, 1'b0, 1'b0, 8'd255});
   endtask

   // monitor and engine model: accepts each command after a variable delay
   always @(negedge clk) begin
      if (cmd_ack_i) begin
         cmd_ack_i = 1'b0;
      end else if (rst_n && cmd_req_o) begin
         if (wait_cnt > 0) begin
            wait_cnt--;
         end else begin
            logic [12:0] got;
            got = {cmd_op_o, cmd_u_o, cmd_v_o, cmd_dst_o, cmd_idx_o};
            if (exp_q.size() == 0) begin
               check(1'b0, "R7", 32'(got), 32'h0);
            end else begin
               logic [12:0] e;
               e = exp_q.pop_front();
               // R2 R6 R8: order, uniform step op, no advance without ack
               check(got == e, tag_of(e), 32'(got), 32'(e));
            end
            cmd_ack_i = 1'b1;
            dly_seed = dly_seed + 1;
            wait_cnt = (dly_seed * 7 + 3) % 5;
         end
      end
   end

   task automatic run_scalar(logic [255:0] k, bit disturb);
      int guard;
      push_expected(k);
      @(negedge clk);
      scalar_i = k;
      start_i  = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R3", 32'(busy_o), 32'h1);
      if (disturb) begin
         repeat (100) @(negedge clk);
         // R9 R10: restart attempt and a new scalar while busy
         scalar_i = ~k;
         start_i  = 1'b1;
         @(negedge clk);
         start_i  = 1'b0;
      end
      guard = 0;
      while (!done_o && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      check(done_o == 1'b1, "R11", 32'(done_o), 32'h1);
      check(busy_o == 1'b0, "R11", 32'(busy_o), 32'h0);
      check(exp_q.size() == 0, "R6", 32'(exp_q.size()), 32'h0);
      @(negedge clk);
      check(done_o == 1'b0, "R11", 32'(done_o), 32'h0);
      check(cmd_req_o == 1'b0, "R7", 32'(cmd_req_o), 32'h0);
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check(busy_o == 1'b0, "R12", 32'(busy_o), 32'h0);
      check(done_o == 1'b0, "R12", 32'(done_o), 32'h0);
      check(cmd_req_o == 1'b0, "R12", 32'(cmd_req_o), 32'h0);
      check(cmd_op_o == 2'd0, "R12", 32'(cmd_op_o), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_scalar('0, 1'b0);
      run_scalar('1, 1'b0);
      run_scalar(256'h0123456789abcdef_fedcba9876543210_a5a5a5a55a5a5a5a_0f0f0f0ff0f0f0f7, 1'b0);
      run_scalar({8{32'hc3a50f96}}, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule